// File: doc/BRIEF.md
# PWM Channel Gate and Period Interrupt Controller

This block holds the run/stop state of a small group of PWM channels and merges their end-of-period events into a single interrupt request. Software reaches it through a plain 32-bit register port with an address, separate write and read strobes, write data and registered read data. The channel counters, the waveform logic and the clock divider live elsewhere. They take the per-channel enable outputs from this block and return a one-cycle pulse at the end of each period.

Run state and interrupt masks are never written directly. One register sets bits, a second clears them, and a third shows the result. A write that carries zeros therefore leaves the other channels alone, so independent drivers need no read-modify-write. Pending events collect in a sticky register. Reading that register returns the pending bits and acknowledges them in the same access. An event that arrives in the cycle of the acknowledge is kept for the next read.

Top module: `pwmirq_ctrl`

## Requirements
- R1: After reset every chan_en bit is 0, the mask reads 0, nothing is pending and irq is 0.
- R2: A write to offset 0x04 sets chan_en[n] for each data bit n that is 1. Bits that are 0 leave their channel unchanged. The new value shows on chan_en in the cycle after the write strobe.
- R3: A write to offset 0x08 clears chan_en[n] for each data bit n that is 1. Bits that are 0 leave their channel unchanged.
- R4: A read of offset 0x0C returns the current chan_en value in bits [NCH-1:0].
- R5: A write to offset 0x10 sets mask bit n for each data bit that is 1. A write to offset 0x14 clears mask bit n for each data bit that is 1. A read of offset 0x18 returns the mask.
- R6: A pulse on period_end[n] makes channel n pending whatever its mask. irq is high in every cycle in which some channel is both pending and masked in.
- R7: A read of offset 0x1C returns the pending bits and clears them in the same access. Read data for every register is valid in the cycle after the read strobe.
- R8: A period_end pulse in the same cycle as a read of offset 0x1C is absent from that read's data and stays pending.
- R9: Data bits at and above NCH read as 0 and are ignored on writes. Offset 0x00 and every unlisted offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (12) | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, registered, valid one cycle after bus_rd |
| period_end | input | NCH (4) | One-cycle end-of-period pulse per channel |
| chan_en | output | NCH (4) | Run enable per channel |
| irq | output | 1 | Interrupt request, level |

## Verification
A corrupted run-state or mask bit shows at the ports one cycle after the write that should have set it: on chan_en directly, or as irq rising or failing to rise after the next period pulse. A pending register that fails to clear on read shows in the next status read and in irq staying high. A lost event shows as a status read that returns zero after a pulse that arrived together with an acknowledge. The bench reads every register back through the bus, so no fault can hide in state that the ports cannot reach.

// File: rtl/pwmirq_pkg.sv
package pwmirq_pkg;

    localparam int unsigned OFF_MODE = 'h00;
    localparam int unsigned OFF_ENA  = 'h04;
    localparam int unsigned OFF_DIS  = 'h08;
    localparam int unsigned OFF_STAT = 'h0C;
    localparam int unsigned OFF_IER  = 'h10;
    localparam int unsigned OFF_IDR  = 'h14;
    localparam int unsigned OFF_IMR  = 'h18;
    localparam int unsigned OFF_ISR  = 'h1C;

    // one-hot register selection produced by the decoder
    typedef struct packed {
        logic ena;
        logic dis;
        logic stat;
        logic ier;
        logic idr;
        logic imr;
        logic isr;
    } reg_sel_t;

    function automatic reg_sel_t decode_offset(input logic [31:0] off, input logic strobe);
        reg_sel_t s;
        s      = '0;
        s.ena  = strobe && (off == OFF_ENA);
        s.dis  = strobe && (off == OFF_DIS);
        s.stat = strobe && (off == OFF_STAT);
        s.ier  = strobe && (off == OFF_IER);
        s.idr  = strobe && (off == OFF_IDR);
        s.imr  = strobe && (off == OFF_IMR);
        s.isr  = strobe && (off == OFF_ISR);
        return s;
    endfunction

endpackage

// File: rtl/pwmirq_decode.sv
module pwmirq_decode
    import pwmirq_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    output reg_sel_t      wsel,
    output reg_sel_t      rsel
);
    logic [31:0] off_ext;

    assign off_ext = 32'(addr);

    always_comb begin
        wsel = decode_offset(off_ext, wr);
        rsel = decode_offset(off_ext, rd);
    end
endmodule

// File: rtl/pwmirq_setclr.sv
module pwmirq_setclr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/pwmirq_pending.sv
module pwmirq_pending #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         ack,
    output logic [W-1:0] pend
);
    // an acknowledge drops the old bits but keeps events of the same cycle
    always_ff @(posedge clk) begin
        if (rst)      pend <= '0;
        else if (ack) pend <= evt;
        else          pend <= pend | evt;
    end
endmodule

// File: rtl/pwmirq_ctrl.sv
module pwmirq_ctrl
    import pwmirq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 12,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] period_end,
    output logic [NCH-1:0] chan_en,
    output logic           irq
);
    reg_sel_t       wsel, rsel;
    logic [NCH-1:0] wbits;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] rd_mux;
    logic [DW-1:0]  rdata_q;

    assign wbits = bus_wdata[NCH-1:0];

    pwmirq_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .wsel (wsel),
        .rsel (rsel)
    );

    pwmirq_setclr #(.W(NCH)) u_run (
        .clk      (clk),
        .rst      (rst),
        .set_bits (wsel.ena ? wbits : '0),
        .clr_bits (wsel.dis ? wbits : '0),
        .q        (chan_en)
    );

    pwmirq_setclr #(.W(NCH)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .set_bits (wsel.ier ? wbits : '0),
        .clr_bits (wsel.idr ? wbits : '0),
        .q        (mask_q)
    );

    pwmirq_pending #(.W(NCH)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .evt  (period_end),
        .ack  (rsel.isr),
        .pend (pend_q)
    );

    always_comb begin
        rd_mux = '0;
        if (rsel.stat) rd_mux = chan_en;
        if (rsel.imr)  rd_mux = mask_q;
        if (rsel.isr)  rd_mux = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= DW'(rd_mux);
    end

    assign bus_rdata = rdata_q;
    assign irq       = |(pend_q & mask_q);
endmodule

// File: rtl/pwmirq_ctrl_chk.sv
module pwmirq_ctrl_chk
    import pwmirq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 12,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic [NCH-1:0] period_end,
    input logic [NCH-1:0] chan_en,
    input logic           irq,
    input logic [NCH-1:0] pend,
    input logic [NCH-1:0] mask
);
    logic seen = 1'b0;
    always_ff @(posedge clk) seen <= 1'b1;

    a_r1_reset_state: assert property (@(posedge clk)
        (seen && $past(rst)) |-> (chan_en == '0 && mask == '0 && pend == '0 && !irq));

    a_r2_enable_sets: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AW'(OFF_ENA)) |=>
        ((chan_en & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

    a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AW'(OFF_DIS)) |=>
        ((chan_en & $past(bus_wdata[NCH-1:0])) == '0));

    a_r5_idr_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AW'(OFF_IDR)) |=>
        ((mask & $past(bus_wdata[NCH-1:0])) == '0));

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(|period_end) || $past(bus_wr && bus_addr == AW'(OFF_IER))));

    a_r7_isr_data: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == AW'(OFF_ISR)) |=> (bus_rdata[NCH-1:0] == $past(pend)));

    a_r8_keep_event: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == AW'(OFF_ISR) && (|period_end)) |=>
        ((pend & $past(period_end)) == $past(period_end)));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DW-1:NCH] == '0);
endmodule

bind pwmirq_ctrl pwmirq_ctrl_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .period_end (period_end),
    .chan_en    (chan_en),
    .irq        (irq),
    .pend       (pend_q),
    .mask       (mask_q)
);

// File: tb/pwmirq_ctrl_bench.sv
module pwmirq_ctrl_bench;
    localparam int NCH = 4;
    localparam int AW  = 12;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic [NCH-1:0] period_end = '0;
    logic [NCH-1:0] chan_en;
    logic           irq;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    logic [NCH-1:0] en_m = '0, mask_m = '0, pend_m = '0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          rd_d = 1'b0;

    always #5 clk = ~clk;

    pwmirq_ctrl #(.NCH(NCH), .AW(AW), .DW(DW)) u_pwmirq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .period_end(period_end),
        .chan_en(chan_en), .irq(irq)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per returned read
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            12'h004: en_m   = en_m | d[NCH-1:0];
            12'h008: en_m   = en_m & ~d[NCH-1:0];
            12'h010: mask_m = mask_m | d[NCH-1:0];
            12'h014: mask_m = mask_m & ~d[NCH-1:0];
            default: ;
        endcase
    endtask

    task automatic do_read(logic [AW-1:0] a, logic [DW-1:0] exp, string tag,
                           logic [NCH-1:0] pe = '0);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; period_end = pe;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0; period_end = '0;
    endtask

    task automatic read_isr(string tag, logic [NCH-1:0] pe = '0);
        do_read(12'h01C, DW'(pend_m), tag, pe);
        pend_m = pe;
    endtask

    task automatic pulse(logic [NCH-1:0] b);
        @(negedge clk);
        period_end = b;
        @(negedge clk);
        period_end = '0;
        pend_m = pend_m | b;
    endtask

    task automatic port_check(string tag);
        check({tag, " chan_en"}, DW'(chan_en), DW'(en_m));
        check({tag, " irq"}, DW'(irq), DW'(|(pend_m & mask_m)));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        port_check("R1 reset");
        do_read(12'h00C, 0, "R1 status after reset");
        do_read(12'h018, 0, "R1 mask after reset");
        read_isr("R1 pending after reset");
        // R2 set, zero bits no effect
        do_write(12'h004, 32'h5);
        port_check("R2 enable 0x5");
        do_write(12'h004, 32'h2);
        port_check("R2 enable 0x2 keeps others");
        // R3 clear
        do_write(12'h008, 32'h4);
        port_check("R3 disable 0x4");
        // R4 status readback
        do_read(12'h00C, DW'(en_m), "R4 status");
        // R9 upper bits ignored, other offsets zero
        do_write(12'h004, 32'hFFFF_FFF0);
        port_check("R9 upper enable bits ignored");
        do_read(12'h00C, DW'(en_m), "R9 status upper zero");
        do_write(12'h000, 32'hFFFF_FFFF);
        do_read(12'h000, 0, "R9 mode reads zero");
        do_read(12'h200, 0, "R9 unlisted offset zero");
        // R5 masks
        do_write(12'h010, 32'h9);
        do_read(12'h018, 32'h9, "R5 mask after set");
        do_write(12'h014, 32'h8);
        do_read(12'h018, 32'h1, "R5 mask after clear");
        // R6 masked-out pending does not raise irq
        pulse(4'h2);
        port_check("R6 masked event");
        read_isr("R7 isr returns ch1");
        read_isr("R7 isr cleared by read");
        // R6 masked-in event raises irq
        pulse(4'h1);
        port_check("R6 unmasked event");
        pulse(4'h1);
        read_isr("R7 repeated event single bit");
        port_check("R7 irq drops after read");
        // R8 event with the acknowledge stays pending
        pulse(4'h4);
        read_isr("R8 read with concurrent event", 4'h1);
        port_check("R8 irq held by kept event");
        read_isr("R8 kept event in next read");
        port_check("R8 irq low after second read");
        // R6 irq rises when mask opens on an old event
        pulse(4'h8);
        port_check("R6 event before mask");
        do_write(12'h010, 32'h8);
        port_check("R6 mask opened later");
        do_write(12'h014, 32'hF);
        port_check("R5 all masks cleared");
        read_isr("R7 final drain");
        repeat (3) @(negedge clk);
        check("scoreboard empty", DW'(exp_q.size()), 0);
        finish_run();
    end
endmodule